// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Invalidation

This block keeps a small number of recent virtual-to-physical page mappings close to the pipeline so that most memory accesses avoid a page table walk. A lookup presents a virtual address, the running process identifier and the kind of access: write or read, user or supervisor. In the same cycle the block reports one of three outcomes. It reports a usable translation, a permission fault, or a miss. Each entry maps exactly one page, so the virtual page number is split only into a set index and a tag. No part of it is used to select a position inside an entry.

On a miss, an external walker returns the mapping through the refill port. The block then installs it in the indexed set. It reuses a way that already holds the same page and process, else the lowest invalid way, else the least recently used way. A flush input empties the whole structure when the page table base changes. A page invalidate input removes one stale mapping after an entry in memory is changed or withdrawn.

The lookup and the controls are plain pins. The refill port is a valid/ready stream. `fill_ready` is low in any cycle in which `flush_all` is high, and a refill offered in that cycle is not taken. At all other times `fill_ready` is high, so a refill is taken on the edge at which `fill_valid` is high.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss.
- R2: The page offset is the low 12 bits of the address. The set index is the low IDX_W bits of the virtual page number, and the tag is the remaining high bits. A lookup hits when a valid entry in the indexed set matches the tag. On a hit `lk_pa` equals the entry's physical page number concatenated with the unchanged offset.
- R3: A refill whose page and process are already held overwrites that entry in place. Otherwise the refill goes to the lowest-numbered invalid way of the set, or to the least recently used way if the set has no invalid way.
- R4: A refill taken on a clock edge is visible to lookups from the next cycle on.
- R5: A lookup that hits without a fault marks its way most recently used, and so does a refill. Each set keeps its own recency order.
- R6: `flush_all` clears every entry on one edge. While `flush_all` is high, `fill_ready` is low and the offered refill is dropped.
- R7: A page invalidate clears, on the next edge, every entry of the indexed set whose tag matches, under any process identifier. It leaves all other entries intact.
- R8: With USE_PID=1 a hit also requires that the entry's stored process identifier equals `lk_pid`.
- R9: A matched entry faults when the access is a write and its writable bit is 0, or when the access is a user access and its user bit is 0. A faulting lookup drives `lk_fault`=1, `lk_hit`=0 and `lk_pa`=0, and it does not change the recency order.
- R10: A refill and a page invalidate of the same page in the same cycle install nothing, because the invalidate wins.
- R11: `lk_miss` is high exactly when `lk_valid` is high and no entry matches. With `lk_valid` low, `lk_hit`, `lk_miss`, `lk_fault` and `lk_pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | VA_W | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_hit | output | 1 | Usable translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Entry found but access not permitted |
| lk_pa | output | PA_W | Translated physical address, 0 unless hit |
| fill_valid | input | 1 | Refill offered |
| fill_ready | output | 1 | Refill can be taken this cycle |
| fill_vpn | input | VA_W-12 | Virtual page of the refill |
| fill_pid | input | PID_W | Process identifier of the refill |
| fill_ppn | input | PA_W-12 | Physical page of the refill |
| fill_wr | input | 1 | Refill writable bit |
| fill_usr | input | 1 | Refill user-accessible bit |
| inval_valid | input | 1 | Invalidate one page |
| inval_vpn | input | VA_W-12 | Page to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the block with its defaults: 32-bit virtual and physical addresses, 2 sets of 2 ways, and process identifiers enabled. With only two ways per set, the third page mapped to a set forces an eviction. The bench can then show that recency decides the victim, that a faulting access leaves recency alone, and that a refill of a page already held replaces it in place. Keeping process identifiers enabled makes it possible to hold one page under two processes at once. The bench then shows that one page invalidate removes both.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef struct packed {
    logic wr;
    logic usr;
  } perm_t;

  function automatic logic perm_violation(perm_t p, logic is_write, logic is_user);
    return (is_write && !p.wr) || (is_user && !p.usr);
  endfunction

endpackage

// File: rtl/xlat_tag_match.sv
module xlat_tag_match #(
  parameter int WAYS    = 2,
  parameter int TAG_W   = 19,
  parameter int PID_W   = 8,
  parameter bit USE_PID = 1'b1
) (
  input  logic [WAYS-1:0]             row_v,
  input  logic [WAYS-1:0][TAG_W-1:0]  row_tag,
  input  logic [WAYS-1:0][PID_W-1:0]  row_pid,
  input  logic [TAG_W-1:0]            q_tag,
  input  logic [PID_W-1:0]            q_pid,
  output logic [WAYS-1:0]             hit_vec
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic pid_ok;
    if (USE_PID) begin : g_pid
      assign pid_ok = (row_pid[w] == q_pid);
    end else begin : g_nopid
      assign pid_ok = 1'b1;
    end
    assign hit_vec[w] = row_v[w] && (row_tag[w] == q_tag) && pid_ok;
  end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int WAYS = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      touch,
  input  logic [$clog2(WAYS)-1:0]   touch_way,
  input  logic [WAYS-1:0]           row_v,
  output logic [$clog2(WAYS)-1:0]   victim
);

  localparam int AGE_W = $clog2(WAYS);

  logic [WAYS-1:0][AGE_W-1:0] age;
  logic [WAYS-1:0]            oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WAYS; i++) age[i] <= AGE_W'(i);
    end else if (touch) begin
      for (int i = 0; i < WAYS; i++) begin
        if (AGE_W'(i) == touch_way)    age[i] <= '0;
        else if (age[i] < age[touch_way]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WAYS; i++) oldest[i] = (age[i] == AGE_W'(WAYS - 1));
  end

  always_comb begin
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (oldest[i]) victim = AGE_W'(i);
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!row_v[i]) victim = AGE_W'(i);
    end
  end

  // R5: recency order stays a permutation, exactly one oldest way
  a_r5_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int SETS    = 2,
  parameter int WAYS    = 2,
  parameter int PID_W   = 8,
  parameter bit USE_PID = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic [PID_W-1:0]      lk_pid,
  input  logic                  lk_write,
  input  logic                  lk_user,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic                  lk_fault,
  output logic [PA_W-1:0]       lk_pa,
  input  logic                  fill_valid,
  output logic                  fill_ready,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PID_W-1:0]      fill_pid,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  fill_wr,
  input  logic                  fill_usr,
  input  logic                  inval_valid,
  input  logic [VA_W-OFF_W-1:0] inval_vpn,
  input  logic                  flush_all
);
  import xlat_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  // entry storage
  logic  [SETS-1:0][WAYS-1:0]             ent_v;
  logic  [SETS-1:0][WAYS-1:0][TAG_W-1:0]  ent_tag;
  logic  [SETS-1:0][WAYS-1:0][PID_W-1:0]  ent_pid;
  logic  [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ent_ppn;
  perm_t [SETS-1:0][WAYS-1:0]             ent_perm;
  logic  [SETS-1:0][WAY_W-1:0]            victim;

  // lookup path
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_idx;
  logic [WAYS-1:0]  m_lk;
  logic [PPN_W-1:0] sel_ppn;
  perm_t            sel_perm;
  logic [WAY_W-1:0] lk_way;
  logic             any_lk, bad_perm;

  assign lk_vpn = lk_va[VA_W-1:OFF_W];
  assign lk_idx = lk_vpn[IDX_W-1:0];

  xlat_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PID_W(PID_W), .USE_PID(USE_PID)) u_match_lk (
    .row_v(ent_v[lk_idx]), .row_tag(ent_tag[lk_idx]), .row_pid(ent_pid[lk_idx]),
    .q_tag(lk_vpn[VPN_W-1:IDX_W]), .q_pid(lk_pid), .hit_vec(m_lk));

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    lk_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m_lk[w]) begin
        sel_ppn  = sel_ppn | ent_ppn[lk_idx][w];
        sel_perm = sel_perm | ent_perm[lk_idx][w];
        lk_way   = lk_way | WAY_W'(w);
      end
    end
  end

  assign any_lk   = |m_lk;
  assign bad_perm = perm_violation(sel_perm, lk_write, lk_user);
  assign lk_hit   = lk_valid && any_lk && !bad_perm;
  assign lk_fault = lk_valid && any_lk && bad_perm;
  assign lk_miss  = lk_valid && !any_lk;
  assign lk_pa    = lk_hit ? {sel_ppn, lk_va[OFF_W-1:0]} : '0;

  // refill path
  logic [IDX_W-1:0] fl_idx;
  logic [WAYS-1:0]  m_fl;
  logic [WAY_W-1:0] fl_way, fl_same_way;
  logic             fill_go;

  assign fill_ready = !flush_all;
  assign fl_idx     = fill_vpn[IDX_W-1:0];
  assign fill_go    = fill_valid && fill_ready && !(inval_valid && inval_vpn == fill_vpn);

  xlat_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PID_W(PID_W), .USE_PID(USE_PID)) u_match_fl (
    .row_v(ent_v[fl_idx]), .row_tag(ent_tag[fl_idx]), .row_pid(ent_pid[fl_idx]),
    .q_tag(fill_vpn[VPN_W-1:IDX_W]), .q_pid(fill_pid), .hit_vec(m_fl));

  always_comb begin
    fl_same_way = '0;
    for (int w = 0; w < WAYS; w++) if (m_fl[w]) fl_same_way = WAY_W'(w);
    fl_way = (|m_fl) ? fl_same_way : victim[fl_idx];
  end

  // page invalidate path: process identifier ignored
  logic [IDX_W-1:0] iv_idx;
  logic [WAYS-1:0]  m_iv;
  assign iv_idx = inval_vpn[IDX_W-1:0];

  xlat_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .PID_W(PID_W), .USE_PID(1'b0)) u_match_iv (
    .row_v(ent_v[iv_idx]), .row_tag(ent_tag[iv_idx]), .row_pid(ent_pid[iv_idx]),
    .q_tag(inval_vpn[VPN_W-1:IDX_W]), .q_pid(lk_pid), .hit_vec(m_iv));

  // recency tracking, refill takes precedence over a lookup in the same set
  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             t_en;
    logic [WAY_W-1:0] t_way;
    assign t_en  = (fill_go && fl_idx == IDX_W'(s)) || (lk_hit && lk_idx == IDX_W'(s));
    assign t_way = (fill_go && fl_idx == IDX_W'(s)) ? fl_way : lk_way;
    xlat_lru #(.WAYS(WAYS)) u_lru (
      .clk(clk), .rst(rst), .touch(t_en), .touch_way(t_way),
      .row_v(ent_v[s]), .victim(victim[s]));
  end

  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      ent_v <= '0;
    end else begin
      if (inval_valid) ent_v[iv_idx] <= ent_v[iv_idx] & ~m_iv;
      if (fill_go)     ent_v[fl_idx][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      ent_tag[fl_idx][fl_way]  <= fill_vpn[VPN_W-1:IDX_W];
      ent_pid[fl_idx][fl_way]  <= fill_pid;
      ent_ppn[fl_idx][fl_way]  <= fill_ppn;
      ent_perm[fl_idx][fl_way] <= '{wr: fill_wr, usr: fill_usr};
    end
  end

  // R3: no page is held twice under one process
  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_lk));
  // R2: the offset passes through unchanged
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);
  // R6: nothing matches in the cycle after a flush
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !lk_hit && !lk_fault);
  // R7 / R10: an invalidated page does not match in the next cycle
  a_r7_inval_removes: assert property (@(posedge clk) disable iff (rst)
    ($past(inval_valid) && lk_valid && lk_vpn == $past(inval_vpn)) |-> !lk_hit && !lk_fault);
  // R4: an accepted refill matches in the next cycle
  a_r4_fill_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid && fill_ready && !(inval_valid && inval_vpn == fill_vpn))
     && lk_valid && lk_vpn == $past(fill_vpn)
     && (!USE_PID || lk_pid == $past(fill_pid))) |-> (lk_hit || lk_fault));

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_pid = '0;
  logic        lk_hit, lk_miss, lk_fault, fill_ready;
  logic [31:0] lk_pa;
  logic        fill_valid = 0, fill_wr = 0, fill_usr = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0, inval_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic        inval_valid = 0, flush_all = 0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        fault;
    logic [31:0] pa;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #(HALF) clk = ~clk;

  xlat_cache dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_pid(lk_pid),
    .lk_write(lk_write), .lk_user(lk_user), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_pa(lk_pa), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn), .fill_wr(fill_wr),
    .fill_usr(fill_usr), .inval_valid(inval_valid), .inval_vpn(inval_vpn),
    .flush_all(flush_all));

  task automatic clear_in();
    lk_valid = 0; lk_write = 0; lk_user = 0;
    fill_valid = 0; inval_valid = 0; flush_all = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input logic [7:0] pid,
                      input logic wr, input logic us, input logic eh, input logic ef,
                      input logic [19:0] eppn, input string req);
    exp_t e;
    @(negedge clk);
    clear_in();
    lk_valid = 1; lk_va = {vpn, off}; lk_pid = pid; lk_write = wr; lk_user = us;
    e.hit = eh; e.fault = ef; e.pa = eh ? {eppn, off} : 32'h0; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [19:0] ppn,
                      input logic w, input logic u);
    @(negedge clk);
    clear_in();
    fill_valid = 1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn; fill_wr = w; fill_usr = u;
  endtask

  task automatic inval(input logic [19:0] vpn);
    @(negedge clk);
    clear_in();
    inval_valid = 1; inval_vpn = vpn;
  endtask

  // monitor: compares each lookup just before the closing edge
  initial begin
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (lk_valid) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R11: lookup with no expectation queued, actual hit=%0b expected none", lk_hit);
        end else begin
          e = exp_q.pop_front();
          n_cmp++;
          if (lk_hit !== e.hit || lk_fault !== e.fault || lk_miss !== (!e.hit && !e.fault)
              || lk_pa !== e.pa) begin
            n_bad++;
            $display("FAIL %s: actual hit=%0b fault=%0b miss=%0b pa=%h expected hit=%0b fault=%0b miss=%0b pa=%h",
                     e.req, lk_hit, lk_fault, lk_miss, lk_pa, e.hit, e.fault,
                     !e.hit && !e.fault, e.pa);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: empty after reset
    look(20'h00440, 12'h030, 8'd1, 0, 0, 0, 0, 20'h0, "R1");
    // R2 / R4: install then translate
    fill(20'h00440, 8'd1, 20'h00554, 1, 1);
    look(20'h00440, 12'h030, 8'd1, 0, 0, 1, 0, 20'h00554, "R2");
    look(20'h00440, 12'hFFF, 8'd1, 1, 1, 1, 0, 20'h00554, "R4");
    // R8: other process misses
    look(20'h00440, 12'h030, 8'd2, 0, 0, 0, 0, 20'h0, "R8");
    // R5: recency picks the victim in set 0
    fill(20'h7FFFE, 8'd1, 20'h00556, 1, 1);
    look(20'h00440, 12'h034, 8'd1, 0, 0, 1, 0, 20'h00554, "R5");
    fill(20'h00664, 8'd1, 20'h005F9, 1, 1);
    look(20'h7FFFE, 12'h008, 8'd1, 0, 0, 0, 0, 20'h0, "R5");
    look(20'h00664, 12'h080, 8'd1, 0, 0, 1, 0, 20'h005F9, "R5");
    look(20'h00440, 12'h038, 8'd1, 0, 0, 1, 0, 20'h00554, "R5");
    // R9: permission faults in set 1
    fill(20'h00123, 8'd1, 20'h00009, 0, 0);
    look(20'h00123, 12'h100, 8'd1, 1, 0, 0, 1, 20'h0, "R9");
    look(20'h00123, 12'h100, 8'd1, 0, 1, 0, 1, 20'h0, "R9");
    look(20'h00123, 12'h100, 8'd1, 0, 0, 1, 0, 20'h00009, "R9");
    fill(20'h7FFFD, 8'd1, 20'h005F8, 1, 1);
    look(20'h00123, 12'h104, 8'd1, 1, 0, 0, 1, 20'h0, "R9");
    fill(20'h00555, 8'd1, 20'h00111, 1, 1);
    look(20'h00123, 12'h104, 8'd1, 0, 0, 0, 0, 20'h0, "R9");
    look(20'h00555, 12'h000, 8'd1, 0, 0, 1, 0, 20'h00111, "R5");
    look(20'h7FFFD, 12'hFF8, 8'd1, 0, 0, 1, 0, 20'h005F8, "R5");
    // R3: refill of a held page replaces it in place
    fill(20'h7FFFD, 8'd1, 20'h00ABC, 1, 1);
    look(20'h7FFFD, 12'hFF0, 8'd1, 1, 0, 1, 0, 20'h00ABC, "R3");
    look(20'h00555, 12'h010, 8'd1, 0, 0, 1, 0, 20'h00111, "R3");
    // R7: single page invalidate
    inval(20'h00555);
    look(20'h00555, 12'h010, 8'd1, 0, 0, 0, 0, 20'h0, "R7");
    look(20'h7FFFD, 12'h000, 8'd1, 0, 0, 1, 0, 20'h00ABC, "R7");
    // R10: refill and invalidate of one page collide
    @(negedge clk);
    clear_in();
    fill_valid = 1; fill_vpn = 20'h00777; fill_pid = 8'd1; fill_ppn = 20'h00777;
    fill_wr = 1; fill_usr = 1; inval_valid = 1; inval_vpn = 20'h00777;
    look(20'h00777, 12'h000, 8'd1, 0, 0, 0, 0, 20'h0, "R10");
    // R8: same page under two processes, R7 clears both
    fill(20'h00010, 8'd3, 20'h00333, 1, 1);
    fill(20'h00010, 8'd4, 20'h00444, 1, 1);
    look(20'h00010, 12'h020, 8'd3, 0, 0, 1, 0, 20'h00333, "R8");
    look(20'h00010, 12'h020, 8'd4, 0, 0, 1, 0, 20'h00444, "R8");
    inval(20'h00010);
    look(20'h00010, 12'h020, 8'd3, 0, 0, 0, 0, 20'h0, "R7");
    look(20'h00010, 12'h020, 8'd4, 0, 0, 0, 0, 20'h0, "R7");
    // R6: flush with a competing refill
    @(negedge clk);
    clear_in();
    flush_all = 1;
    fill_valid = 1; fill_vpn = 20'h00888; fill_pid = 8'd1; fill_ppn = 20'h00888;
    #1;
    n_cmp++;
    if (fill_ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R6: actual fill_ready=%0b expected 0", fill_ready);
    end
    look(20'h7FFFD, 12'h000, 8'd1, 0, 0, 0, 0, 20'h0, "R6");
    look(20'h00888, 12'h000, 8'd1, 0, 0, 0, 0, 20'h0, "R6");
    look(20'h00664, 12'h000, 8'd1, 0, 0, 0, 0, 20'h0, "R6");
    // R11: idle lookup drives nothing
    @(negedge clk);
    clear_in();
    lk_va = {20'h00664, 12'h000};
    #(HALF - 1);
    n_cmp++;
    if (lk_hit !== 0 || lk_miss !== 0 || lk_fault !== 0 || lk_pa !== 32'h0) begin
      n_bad++;
      $display("FAIL R11: actual hit=%0b miss=%0b fault=%0b pa=%h expected all 0",
               lk_hit, lk_miss, lk_fault, lk_pa);
    end
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: actual %0d expectations left, expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule